// File: doc/BRIEF.md
# GPIO Interrupt Detect and Status

This block turns the sampled levels of a bank of general-purpose pins into interrupt requests. Each pin carries a two-bit trigger choice, a detect-kind bit and a polarity bit. Together they select rising edge, falling edge, low level or high level. A detected event sets a sticky status bit. The polarity bit means "falling" in edge mode and "high" in level mode, so level detection is active-low unless that bit is set.

Status bits are grouped into 32-bit words. Software clears them one word at a time with a write-one-to-clear port. Each status bit is ANDed with its enable bit to give a pending vector, padded to whole words, which a handler can scan. The OR of all pending bits is registered and drives the single interrupt output. A pin that firmware keeps for itself, or whose input sensing is off, never produces an event. Pad levels arrive already synchronized to the block clock.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, `status_o`, `pending_o` and `irq_o` are all zero.
- R2: With `trig_level`=0 and `trig_inv`=0, a pin's status bit becomes 1 after the clock edge at which its sampled level is 1 and the level sampled at the edge before was 0.
- R3: With `trig_level`=0 and `trig_inv`=1, the status bit becomes 1 after the edge at which the level is 0 and the previous sample was 1. A rising level does nothing in this mode.
- R4: With `trig_level`=1 the pin has an event on every edge at which its level is active: 0 when `trig_inv`=0, 1 when `trig_inv`=1.
- R5: A clear request with `clr_valid`=1, word index w and mask m clears status of pin 32*w+b for every bit b set in m. Bits where m is 0 keep their value, pins in other words are unaffected, m of all ones clears the whole word, and an index of 3 or more changes nothing.
- R6: A status bit stays 1 until it is cleared. A level-mode pin whose level is still active stays 1 through a clear.
- R7: When an event and a clear for the same pin fall on the same edge, the event wins and the bit stays 1.
- R8: A pin with `host_own`=0 (reserved for firmware) never sets its status bit.
- R9: A pin with `sense_en`=0 never sets its status bit.
- R10: `pending_o` bit 32*w+b equals status AND enable of pin 32*w+b. Padding bits above the last pin are 0.
- R11: `irq_o` is registered: after each edge it equals the OR of `pending_o` as it was before that edge.
- R12: The edge detector loads the current level during reset, so a pin already high in rising mode produces no event after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_level | input | NUM_PINS | Synchronized pad levels |
| sense_en | input | NUM_PINS | Input sensing enable per pin |
| host_own | input | NUM_PINS | 1: pin usable as interrupt source; 0: reserved for firmware |
| trig_level | input | NUM_PINS | Detect kind: 0 edge, 1 level |
| trig_inv | input | NUM_PINS | Polarity: falling (edge) or high (level) when 1 |
| irq_en | input | NUM_PINS | Interrupt enable per pin |
| clr_valid | input | 1 | Clear request strobe |
| clr_word | input | 2 | Word index of the clear request |
| clr_mask | input | 32 | Write-one-to-clear mask for that word |
| status_o | output | NUM_PINS | Sticky status bits |
| pending_o | output | 96 | Status AND enable, padded to whole words |
| irq_o | output | 1 | Registered aggregated interrupt |

## Verification
The edge assertions assume the level input changes only between clock edges and reaches the block already synchronized. The bench therefore drives every input one time unit after a rising edge and reads outputs at that point too. The clear and sticky assertions assume that configuration changes are themselves treated as events when they make a level condition true. To keep spurious events out of expected values, the bench returns pins to rising mode at level 0, or changes mode and level in an order that creates no edge.

// File: rtl/gpio_irq_pkg.sv
// Package: shared trigger encoding and sizing helpers for the GPIO interrupt block.
// Assumes: the trigger code is formed as {detect-kind, polarity}.
package gpio_irq_pkg;

    // Trigger code {trig_level, trig_inv}
    typedef enum logic [1:0] {
        TRIG_RISE = 2'b00,
        TRIG_FALL = 2'b01,
        TRIG_LOW  = 2'b10,
        TRIG_HIGH = 2'b11
    } trig_mode_e;

    // Number of whole words needed to cover a pin count
    function automatic int words_for(input int pins, input int word_w);
        return (pins + word_w - 1) / word_w;
    endfunction

    // Index width for a word count, never zero
    function automatic int idx_width(input int words);
        return (words > 1) ? $clog2(words) : 1;
    endfunction

endpackage

// File: rtl/gpio_irq_pin_detect.sv
// Module: per-pin event detector.
// Compares the current sampled level with the previous one for edge modes and
// tests the level directly for level modes. Events are gated by input sensing
// and by host ownership. Assumes level_i is already synchronous to clk.
module gpio_irq_pin_detect
    import gpio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    input  logic sense_i,
    input  logic own_i,
    input  logic kind_i,
    input  logic inv_i,
    output logic event_o
);

    logic       prev_q;
    logic       raw_evt;
    trig_mode_e mode;

    assign mode = trig_mode_e'({kind_i, inv_i});

    // Hold previous level; reset loads the live level so no edge appears at release
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= level_i;
        else        prev_q <= level_i;
    end

    // Decode trigger mode into a raw event
    always_comb begin
        unique case (mode)
            TRIG_RISE: raw_evt = level_i & ~prev_q;
            TRIG_FALL: raw_evt = ~level_i & prev_q;
            TRIG_LOW:  raw_evt = ~level_i;
            TRIG_HIGH: raw_evt = level_i;
            default:   raw_evt = 1'b0;
        endcase
    end

    assign event_o = raw_evt & sense_i & own_i;

    // R2: a rising-mode event needs a 0-to-1 change of the sampled level
    a_r2_rise_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (event_o && !kind_i && !inv_i) |-> (level_i && !$past(level_i)));

    // R3: a falling-mode event needs a 1-to-0 change of the sampled level
    a_r3_fall_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (event_o && !kind_i && inv_i) |-> (!level_i && $past(level_i)));

endmodule

// File: rtl/gpio_irq_status.sv
// Module: sticky status register with word-wise write-one-to-clear.
// A clear names one word and a mask; an event on the same edge wins over a clear.
// Assumes clear requests are single-cycle strobes; indices beyond the last word are ignored.
module gpio_irq_status
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 95,
    parameter int WORD_W   = 32,
    localparam int NUM_WORDS  = words_for(NUM_PINS, WORD_W),
    localparam int WORD_IDX_W = idx_width(NUM_WORDS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PINS-1:0]   event_i,
    input  logic                  clr_valid,
    input  logic [WORD_IDX_W-1:0] clr_word,
    input  logic [WORD_W-1:0]     clr_mask,
    output logic [NUM_PINS-1:0]   status_o
);

    logic [NUM_PINS-1:0] clr_vec;
    logic [NUM_PINS-1:0] status_q;

    // Expand the word clear into a per-pin clear vector
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_clr
        localparam int WIDX = p / WORD_W;
        localparam int BIDX = p % WORD_W;
        assign clr_vec[p] = clr_valid
                          && (clr_word == WORD_IDX_W'(WIDX))
                          && clr_mask[BIDX];
    end

    // Update sticky status: clear first, then new events set
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_vec) | event_i;
    end

    assign status_o = status_q;

    // R5: a cleared pin without a new event reads 0 after the edge
    a_r5_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & $past(clr_vec & ~event_i)) == '0));

    // R6: a set bit is never lost unless a clear named it
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(status_q) & ~$past(clr_vec) & ~status_q) == '0));

    // R7: an event always leaves its bit set
    a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(event_i) & ~status_q) == '0));

endmodule

// File: rtl/gpio_irq_aggr.sv
// Module: pending-vector builder and registered interrupt aggregator.
// Pads status and enable to whole words, ANDs them and ORs every pending bit
// into one registered request.
module gpio_irq_aggr
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 95,
    parameter int WORD_W   = 32,
    localparam int NUM_WORDS = words_for(NUM_PINS, WORD_W),
    localparam int PAD_W     = NUM_WORDS * WORD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] status_i,
    input  logic [NUM_PINS-1:0] enable_i,
    output logic [PAD_W-1:0]    pending_o,
    output logic                irq_o
);

    logic [PAD_W-1:0]     stat_pad;
    logic [PAD_W-1:0]     en_pad;
    logic [NUM_WORDS-1:0] word_hit;
    logic                 irq_q;

    assign stat_pad  = PAD_W'(status_i);
    assign en_pad    = PAD_W'(enable_i);
    assign pending_o = stat_pad & en_pad;

    // One OR per word, then across words
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        assign word_hit[w] = |pending_o[w*WORD_W +: WORD_W];
    end

    // Register the aggregated request
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |word_hit;
    end

    assign irq_o = irq_q;

    // R11: the output follows the previous cycle's pending bits
    a_r11_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == ($past(status_i & enable_i) != '0)));

endmodule

// File: rtl/gpio_irq_ctrl.sv
// Module: top of the GPIO interrupt detect and status block.
// Instantiates one detector per pin, the sticky status register and the
// aggregator. Assumes all inputs are synchronous to clk.
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 95,
    parameter int WORD_W   = 32,
    localparam int NUM_WORDS  = words_for(NUM_PINS, WORD_W),
    localparam int WORD_IDX_W = idx_width(NUM_WORDS),
    localparam int PAD_W      = NUM_WORDS * WORD_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PINS-1:0]   pin_level,
    input  logic [NUM_PINS-1:0]   sense_en,
    input  logic [NUM_PINS-1:0]   host_own,
    input  logic [NUM_PINS-1:0]   trig_level,
    input  logic [NUM_PINS-1:0]   trig_inv,
    input  logic [NUM_PINS-1:0]   irq_en,
    input  logic                  clr_valid,
    input  logic [WORD_IDX_W-1:0] clr_word,
    input  logic [WORD_W-1:0]     clr_mask,
    output logic [NUM_PINS-1:0]   status_o,
    output logic [PAD_W-1:0]      pending_o,
    output logic                  irq_o
);

    logic [NUM_PINS-1:0] pin_evt;

    // One detector per pin
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        gpio_irq_pin_detect i_det (
            .clk     (clk),
            .rst_n   (rst_n),
            .level_i (pin_level[p]),
            .sense_i (sense_en[p]),
            .own_i   (host_own[p]),
            .kind_i  (trig_level[p]),
            .inv_i   (trig_inv[p]),
            .event_o (pin_evt[p])
        );
    end

    gpio_irq_status #(
        .NUM_PINS (NUM_PINS),
        .WORD_W   (WORD_W)
    ) i_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .event_i   (pin_evt),
        .clr_valid (clr_valid),
        .clr_word  (clr_word),
        .clr_mask  (clr_mask),
        .status_o  (status_o)
    );

    gpio_irq_aggr #(
        .NUM_PINS (NUM_PINS),
        .WORD_W   (WORD_W)
    ) i_aggr (
        .clk       (clk),
        .rst_n     (rst_n),
        .status_i  (status_o),
        .enable_i  (irq_en),
        .pending_o (pending_o),
        .irq_o     (irq_o)
    );

    // R8 and R9: a status bit rises only if the pin was owned and sensing
    a_r8_owner_gate: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_o & ~$past(status_o) & ~$past(host_own & sense_en)) == '0));

endmodule

// File: tb/test_gpio_irq_ctrl.sv
// Directed bench: one task per scenario, each checking its own results.
module test_gpio_irq_ctrl;

    localparam int NP = 95;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pin_level = '0;
    logic [NP-1:0] sense_en = '1;
    logic [NP-1:0] host_own = '1;
    logic [NP-1:0] trig_level = '0;
    logic [NP-1:0] trig_inv = '0;
    logic [NP-1:0] irq_en = '0;
    logic          clr_valid = 1'b0;
    logic [1:0]    clr_word = '0;
    logic [31:0]   clr_mask = '0;
    logic [NP-1:0] status_o;
    logic [95:0]   pending_o;
    logic          irq_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    gpio_irq_ctrl i_gpio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .pin_level(pin_level), .sense_en(sense_en),
        .host_own(host_own), .trig_level(trig_level), .trig_inv(trig_inv),
        .irq_en(irq_en), .clr_valid(clr_valid), .clr_word(clr_word),
        .clr_mask(clr_mask), .status_o(status_o), .pending_o(pending_o),
        .irq_o(irq_o)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_word(input int w, input logic [31:0] m);
        clr_valid = 1'b1;
        clr_word  = 2'(w);
        clr_mask  = m;
        step();
        clr_valid = 1'b0;
        clr_mask  = '0;
    endtask

    task automatic clear_all();
        for (int w = 0; w < 3; w++) clear_word(w, 32'hFFFF_FFFF);
        step();
    endtask

    // R1, R12: reset state; a pin high during reset gives no edge after release
    task automatic t_reset();
        pin_level[1] = 1'b1;
        irq_en = '1;
        repeat (3) step();
        chk("R1 status in reset", 128'(status_o), 128'(0));
        chk("R1 irq in reset", 128'(irq_o), 128'(0));
        rst_n = 1'b1;
        step();
        chk("R1 pending after release", 128'(pending_o), 128'(0));
        step();
        chk("R12 no spurious edge", 128'(status_o[1]), 128'(1'b0));
        pin_level[1] = 1'b0;
        irq_en = '0;
        step();
    endtask

    // R2, R11: rising edge sets status, irq follows one cycle later
    task automatic t_rise();
        irq_en[5] = 1'b1;
        pin_level[5] = 1'b1;
        step();
        chk("R2 rising sets", 128'(status_o), 128'(1) << 5);
        chk("R11 irq not yet", 128'(irq_o), 128'(0));
        step();
        chk("R11 irq asserted", 128'(irq_o), 128'(1));
        pin_level[5] = 1'b0;
        step();
        chk("R2 fall ignored in rise mode", 128'(status_o), 128'(1) << 5);
        clear_word(0, 32'h0000_0020);
        chk("R5 cleared pin5", 128'(status_o), 128'(0));
        chk("R11 irq still high one cycle", 128'(irq_o), 128'(1));
        step();
        chk("R11 irq drops", 128'(irq_o), 128'(0));
        irq_en = '0;
    endtask

    // R3: falling mode on pin 40
    task automatic t_fall();
        trig_inv[40] = 1'b1;
        step();
        pin_level[40] = 1'b1;
        step();
        chk("R3 rise ignored", 128'(status_o), 128'(0));
        pin_level[40] = 1'b0;
        step();
        chk("R3 falling sets", 128'(status_o), 128'(1) << 40);
        trig_inv[40] = 1'b0;
        clear_all();
    endtask

    // R4, R6: level modes; active level survives a clear
    task automatic t_level();
        trig_level[70] = 1'b1;
        step();
        chk("R4 low level sets", 128'(status_o), 128'(1) << 70);
        clear_word(2, 32'h0000_0040);
        chk("R6 active level stays set", 128'(status_o), 128'(1) << 70);
        pin_level[70] = 1'b1;
        step();
        clear_word(2, 32'h0000_0040);
        chk("R4 inactive level clears", 128'(status_o), 128'(0));
        trig_level[94] = 1'b1;
        trig_inv[94]   = 1'b1;
        step();
        chk("R4 high level idle", 128'(status_o), 128'(0));
        pin_level[94] = 1'b1;
        step();
        chk("R4 high level sets last pin", 128'(status_o), 128'(1) << 94);
        trig_level[70] = 1'b0; pin_level[70] = 1'b0;
        trig_level[94] = 1'b0; trig_inv[94] = 1'b0; pin_level[94] = 1'b0;
        step();
        clear_all();
        chk("R5 all-ones clears", 128'(status_o), 128'(0));
    endtask

    // R5, R10: partial clears, bad index, pending layout
    task automatic t_clear_pending();
        pin_level[3] = 1'b1; pin_level[7] = 1'b1; pin_level[40] = 1'b1;
        step();
        irq_en[40] = 1'b1;
        step();
        chk("R10 pending layout", 128'(pending_o), 128'(1) << 40);
        clear_word(3, 32'hFFFF_FFFF);
        chk("R5 bad index ignored", 128'(status_o),
            (128'(1) << 3) | (128'(1) << 7) | (128'(1) << 40));
        clear_word(0, 32'h0000_0008);
        chk("R5 zero bits kept", 128'(status_o), (128'(1) << 7) | (128'(1) << 40));
        clear_word(0, 32'hFFFF_FFFF);
        chk("R5 other word untouched", 128'(status_o), 128'(1) << 40);
        irq_en[40] = 1'b0;
        step();
        chk("R10 enable gates pending", 128'(pending_o), 128'(0));
        pin_level = '0;
        clear_all();
    endtask

    // R7: event and clear on the same edge
    task automatic t_collide();
        pin_level[10] = 1'b1;
        step();
        pin_level[10] = 1'b0;
        step();
        pin_level[10] = 1'b1;
        clear_word(0, 32'h0000_0400);
        chk("R7 event wins", 128'(status_o), 128'(1) << 10);
        clear_word(0, 32'h0000_0400);
        chk("R7 plain clear after", 128'(status_o), 128'(0));
        pin_level[10] = 1'b0;
        step();
    endtask

    // R8, R9: firmware-owned and non-sensing pins raise nothing
    task automatic t_gating();
        host_own[20] = 1'b0;
        sense_en[60] = 1'b0;
        irq_en = '1;
        step();
        pin_level[20] = 1'b1; pin_level[60] = 1'b1;
        step();
        step();
        chk("R8 owned pin silent", 128'(status_o[20]), 128'(1'b0));
        chk("R9 sensing off silent", 128'(status_o[60]), 128'(1'b0));
        chk("R8 irq stays low", 128'(irq_o), 128'(0));
        pin_level = '0; host_own = '1; sense_en = '1; irq_en = '0;
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_rise();
        t_fall();
        t_level();
        t_clear_pending();
        t_collide();
        t_gating();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule